// File: doc/BRIEF.md
# MDIO PHY Management Controller

This block is a register-driven MDIO master for clause 22 management frames. Software fills one 32-bit management word with the complete frame: start code, opcode, PHY address, register number, turnaround and data. A single write to that word starts the operation. The block sends a preamble of 32 ones and then the 32 frame bits, most significant bit first. For a read it releases the data line and samples the 16 data bits the PHY returns. When the operation ends, those bits replace the low half of the same word.

A status bit shows whether the port is idle. Software polls it before it starts an operation and again before it reads a result. An enable bit in the control register gates the port. A write made while the port is disabled stays pending until the port is enabled. The MDC clock is the bus clock divided by a ratio chosen with a 3-bit code in the configuration register.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: Status register (index 2) bit 2 reads 1 only when no management operation is in progress or pending. After reset it reads 1.
- R2: A write to the management word (index 3) while idle starts an operation. MDIO carries 32 ones and then the 32 bits of the word, bit 31 first, one bit per MDC period.
- R3: MDIO output changes only together with a falling edge of MDC. The PHY's data is sampled on the rising edge.
- R4: In a read (word bits 29:28 = 10), mdio_oe is low from the second turnaround bit (frame bit 47) through the last data bit (frame bit 63). In a write (bits 29:28 = 01), mdio_oe stays high for all 64 bits. mdio_oe is low whenever the port is idle.
- R5: When a read completes, the 16 sampled bits (first sampled = bit 15) replace word bits 15:0 and bits 31:16 keep their value. A write operation leaves the word unchanged.
- R6: A write to the management word while an operation is in progress is ignored. The word keeps its value, and the frame on the line is the original one.
- R7: While control register (index 0) bit 4 is clear, MDC stays low and no operation advances. A pending operation runs to completion once the bit is set.
- R8: Configuration register (index 1) bits 20:18 select the MDC period in bus clocks: 0→8, 1→16, 2→32, 3→48, 4→64, 5→96, 6→128, 7→224. The high and low phases are each half of the period.
- R9: After reset, control and configuration read 0, MDC is low and mdio_oe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 control, 1 config, 2 status, 3 management word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Resolved MDIO line value |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The hardest situation to reach is an operation held while the port is disabled. In that state the status must show busy, yet MDC must stay quiet. The bench clears the enable bit, loads a read word, and waits hundreds of cycles while it counts MDC edges and polls the status. It then sets the enable bit and checks the complete frame. The ignored write needs an operation to be mid-flight, so the bench writes a second word a few MDC periods into a read and checks both the read-back word and the frame seen by its PHY model.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int unsigned REG_IDX_W     = 2;
    localparam logic [1:0]  IDX_CTRL      = 2'd0;
    localparam logic [1:0]  IDX_CFG       = 2'd1;
    localparam logic [1:0]  IDX_STAT      = 2'd2;
    localparam logic [1:0]  IDX_WORD      = 2'd3;

    localparam int unsigned CTRL_EN_POS   = 4;
    localparam int unsigned CFG_DIV_LSB   = 18;
    localparam int unsigned DIV_CODE_W    = 3;
    localparam int unsigned STAT_IDLE_POS = 2;

    localparam int unsigned PREAMBLE_LEN  = 32;
    localparam int unsigned WORD_LEN      = 32;
    localparam int unsigned SEQ_LEN       = PREAMBLE_LEN + WORD_LEN;
    localparam int unsigned SEQ_IDX_W     = $clog2(SEQ_LEN);
    localparam int unsigned RD_DATA_W     = 16;
    localparam int unsigned RELEASE_IDX   = SEQ_LEN - RD_DATA_W - 1;
    localparam int unsigned SAMPLE_IDX    = SEQ_LEN - RD_DATA_W;

    typedef enum logic [1:0] {
        OPC_NONE0 = 2'b00,
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10,
        OPC_NONE3 = 2'b11
    } mgmt_opc_e;

    typedef struct packed {
        logic [1:0]           start_code;
        mgmt_opc_e            opcode;
        logic [4:0]           phy_id;
        logic [4:0]           reg_id;
        logic [1:0]           turn;
        logic [RD_DATA_W-1:0] payload;
    } mgmt_word_t;

    function automatic int unsigned mdc_ratio(input logic [DIV_CODE_W-1:0] code);
        case (code)
            3'd0:    return 8;
            3'd1:    return 16;
            3'd2:    return 32;
            3'd3:    return 48;
            3'd4:    return 64;
            3'd5:    return 96;
            3'd6:    return 128;
            default: return 224;
        endcase
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
    import mdio_mgmt_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run,
    input  logic [DIV_CODE_W-1:0] code,
    output logic                  mdc,
    output logic                  rise_tick,
    output logic                  fall_tick
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] half;
    logic             phase_end;

    assign half      = CNT_W'(mdc_ratio(code) >> 1);
    assign phase_end = (cnt_q == half - CNT_W'(1));
    assign rise_tick = run && !mdc && phase_end;
    assign fall_tick = run &&  mdc && phase_end;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (phase_end) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  mgmt_word_t           word,
    input  logic                 rise_tick,
    input  logic                 fall_tick,
    input  logic                 mdio_i,
    output logic                 busy,
    output logic                 is_read,
    output logic                 done,
    output logic [RD_DATA_W-1:0] captured,
    output logic                 mdio_o,
    output logic                 mdio_oe
);

    logic [SEQ_LEN-1:0]   seq_q;
    logic [SEQ_IDX_W-1:0] idx_q;
    logic                 last_bit;
    logic                 released;

    assign last_bit = (idx_q == SEQ_IDX_W'(SEQ_LEN - 1));
    assign done     = busy && fall_tick && last_bit;
    assign released = is_read && (idx_q >= SEQ_IDX_W'(RELEASE_IDX));
    assign mdio_o   = busy ? seq_q[SEQ_LEN-1] : 1'b1;
    assign mdio_oe  = busy && !released;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            is_read  <= 1'b0;
            idx_q    <= '0;
            seq_q    <= '1;
            captured <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            is_read  <= (word.opcode == OPC_READ);
            idx_q    <= '0;
            seq_q    <= {{PREAMBLE_LEN{1'b1}}, word};
            captured <= '0;
        end else if (busy) begin
            if (rise_tick && is_read && idx_q >= SEQ_IDX_W'(SAMPLE_IDX)) begin
                captured <= {captured[RD_DATA_W-2:0], mdio_i};
            end
            if (fall_tick) begin
                if (last_bit) begin
                    busy <= 1'b0;
                end else begin
                    idx_q <= idx_q + SEQ_IDX_W'(1);
                    seq_q <= {seq_q[SEQ_LEN-2:0], 1'b1};
                end
            end
        end
    end

endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
    import mdio_mgmt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [REG_IDX_W-1:0]  reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic                  busy,
    input  logic                  done,
    input  logic                  is_read,
    input  logic [RD_DATA_W-1:0]  captured,
    output logic                  port_en,
    output logic [DIV_CODE_W-1:0] div_code,
    output logic                  start,
    output mgmt_word_t            word_q
);

    assign start = reg_wr && (reg_addr == IDX_WORD) && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            port_en  <= 1'b0;
            div_code <= '0;
            word_q   <= '0;
        end else begin
            if (reg_wr && reg_addr == IDX_CTRL) port_en  <= reg_wdata[CTRL_EN_POS];
            if (reg_wr && reg_addr == IDX_CFG)
                div_code <= reg_wdata[CFG_DIV_LSB +: DIV_CODE_W];
            if (start) begin
                word_q <= mgmt_word_t'(reg_wdata);
            end else if (done && is_read) begin
                word_q.payload <= captured;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            IDX_CTRL: reg_rdata[CTRL_EN_POS]                = port_en;
            IDX_CFG:  reg_rdata[CFG_DIV_LSB +: DIV_CODE_W]  = div_code;
            IDX_STAT: reg_rdata[STAT_IDLE_POS]              = !busy;
            default:  reg_rdata                             = word_q;
        endcase
    end

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_mgmt_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe
);

    logic                  busy;
    logic                  is_read;
    logic                  done;
    logic [RD_DATA_W-1:0]  captured;
    logic                  mdio_en;
    logic [DIV_CODE_W-1:0] div_code;
    logic                  start;
    mgmt_word_t            word_q;
    logic                  rise_tick;
    logic                  fall_tick;
    logic [15:0]           word_hi;

    assign word_hi = word_q[31:16];

    mdio_reg_bank u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .done      (done),
        .is_read   (is_read),
        .captured  (captured),
        .port_en   (mdio_en),
        .div_code  (div_code),
        .start     (start),
        .word_q    (word_q)
    );

    mdio_mdc_gen #(.CNT_W(CNT_W)) u_mdc (
        .clk       (clk),
        .rst       (rst),
        .run       (mdio_en && busy),
        .code      (div_code),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .word      (mgmt_word_t'(reg_wdata)),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .is_read   (is_read),
        .done      (done),
        .captured  (captured),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic        busy,
    input logic        mdio_en,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic [15:0] word_hi
);

    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd3 && !busy) |=> busy);

    p_drive_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));

    p_oe_only_busy_r4: assert property (@(posedge clk) disable iff (rst)
        mdio_oe |-> busy);

    p_busy_write_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd3 && busy) |=> $stable(word_hi));

    p_mdc_low_disabled_r7: assert property (@(posedge clk) disable iff (rst)
        (!mdio_en && $past(!mdio_en)) |-> !mdc);

    p_mdc_rise_enabled_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(mdc) |-> $past(mdio_en && busy));

endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .busy     (busy),
    .mdio_en  (mdio_en),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .word_hi  (word_hi)
);

// File: tb/sim_mdio_mgmt_ctrl.sv
module sim_mdio_mgmt_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int tests = 0;
    int fails = 0;

    logic        phy_oe = 1'b0;
    logic        phy_v  = 1'b1;
    logic        rd_mode = 1'b0;
    logic [15:0] phy_data = '0;
    int          rise_cnt = 0;
    logic [63:0] line_seen;
    logic [63:0] oe_seen;
    longint      cyc = 0;
    longint      rise_at [0:63];
    longint      fall_at [0:63];
    int          fall_cnt = 0;

    always #2 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : (phy_oe ? phy_v : 1'b1);

    mdio_mgmt_ctrl u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mdio_oe && phy_oe) begin
            tests++; fails++;
            $display("FAIL R4: line contention, mdio_oe=%0b phy_oe=%0b expected one driver", mdio_oe, phy_oe);
        end
    end

    always @(posedge mdc) begin
        if (rise_cnt < 64) begin
            line_seen[63 - rise_cnt] = mdio_i;
            oe_seen[63 - rise_cnt]   = mdio_oe;
            rise_at[rise_cnt]        = cyc;
        end
        rise_cnt++;
    end

    always @(negedge mdc) begin
        if (fall_cnt < 64) fall_at[fall_cnt] = cyc;
        fall_cnt++;
        if (rd_mode && rise_cnt >= 47 && rise_cnt <= 63) begin
            phy_oe = 1'b1;
            phy_v  = (rise_cnt == 47) ? 1'b0 : phy_data[63 - rise_cnt];
        end else begin
            phy_oe = 1'b0;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(2'd2, s);
            if (s[2]) return;
        end
    endtask

    task automatic arm(input logic [31:0] w);
        rise_cnt = 0; fall_cnt = 0;
        rd_mode = (w[29:28] == 2'b10);
        line_seen = '0; oe_seen = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd2, d); check("R1 idle after reset", 64'(d[2]), 64'd1);
        rd(2'd0, d); check("R9 control reset", 64'(d), 64'd0);
        rd(2'd1, d); check("R9 config reset", 64'(d), 64'd0);
        check("R9 mdc/oe reset", {62'd0, mdc, mdio_oe}, 64'd0);
    endtask

    task automatic t_write_op(input logic [31:0] w);
        logic [31:0] d;
        arm(w);
        wr(2'd3, w);
        rd(2'd2, d); check("R1 busy after start", 64'(d[2]), 64'd0);
        wait_idle();
        check("R2 write frame on line", line_seen, {32'hFFFF_FFFF, w});
        check("R4 write keeps oe", oe_seen, '1);
        rd(2'd3, d); check("R5 write leaves word", 64'(d), 64'(w));
        check("R4 oe low when idle", 64'(mdio_oe), 64'd0);
    endtask

    task automatic t_read_op(input logic [31:0] w, input logic [15:0] pd);
        logic [31:0] d;
        phy_data = pd;
        arm(w);
        wr(2'd3, w);
        wait_idle();
        check("R2 read header on line", 64'(line_seen[63:17]), 64'({32'hFFFF_FFFF, w[31:17]}));
        check("R4 read release", oe_seen, {{47{1'b1}}, 17'd0});
        check("R3 sampled data on rising edges", 64'(line_seen[15:0]), 64'(pd));
        rd(2'd3, d); check("R5 read result in word", 64'(d), 64'({w[31:16], pd}));
    endtask

    task automatic t_busy_ignore();
        logic [31:0] w1, w2, d;
        w1 = 32'h6A3E_0000; w2 = 32'h5555_AAAA;
        phy_data = 16'h0F0F;
        arm(w1);
        wr(2'd3, w1);
        repeat (40) @(negedge clk);
        wr(2'd3, w2);
        rd(2'd3, d); check("R6 word unchanged by busy write", 64'(d), 64'(w1));
        wait_idle();
        check("R6 original frame kept", 64'(line_seen[63:17]), 64'({32'hFFFF_FFFF, w1[31:17]}));
        rd(2'd3, d); check("R6 result of original read", 64'(d), 64'({w1[31:16], 16'h0F0F}));
    endtask

    task automatic t_enable_gate();
        logic [31:0] w, d;
        w = 32'h6086_0000;
        phy_data = 16'hC3A5;
        wr(2'd0, 32'h0);
        arm(w);
        wr(2'd3, w);
        repeat (300) @(negedge clk);
        check("R7 no mdc while disabled", 64'(rise_cnt), 64'd0);
        rd(2'd2, d); check("R1 pending shows busy", 64'(d[2]), 64'd0);
        wr(2'd0, 32'h10);
        wait_idle();
        check("R7 frame after enable", 64'(rise_cnt), 64'd64);
        rd(2'd3, d); check("R7 pending read completes", 64'(d), 64'({w[31:16], 16'hC3A5}));
    endtask

    task automatic t_divider(input logic [2:0] code, input int per);
        logic [31:0] w;
        w = 32'h5FFE_1234;
        wr(2'd1, 32'(code) << 18);
        arm(w);
        wr(2'd3, w);
        wait_idle();
        check("R8 mdc period", 64'(rise_at[6] - rise_at[5]), 64'(per));
        check("R8 mdc high phase", 64'(fall_at[5] - rise_at[5]), 64'(per / 2));
        check("R2 frame with divider", line_seen, {32'hFFFF_FFFF, w});
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        wr(2'd0, 32'h10);
        t_write_op(32'h5086_1D5C);
        t_write_op(32'h57C2_0001);
        t_read_op(32'h6A02_0000, 16'h796D);
        t_read_op(32'h6FFE_FFFF, 16'h0001);
        t_busy_ignore();
        t_enable_gate();
        t_divider(3'd3, 48);
        t_divider(3'd4, 64);
        t_divider(3'd0, 8);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule